// File: doc/BRIEF.md
# Vector Display Control-Flow and Position Unit

This block is the control-flow part of a vector display processor. It holds the display program counter and a bank register. It also holds a return-address stack with eight entries, a running flag, and the X and Y beam position registers. Each cycle it accepts at most one decoded instruction strobe and commits the result at the next clock edge. The strobes are jump, call, return, set bank, load X, load Y, add the most significant step to X or Y, and halt.

A jump target is the bank register placed above the 12-bit address field, which gives a 16-bit program address. A call saves the current program counter on the stack before it jumps. A return restores the most recent saved address. A return with nothing saved, or a call with the stack already full, is a fault. A fault raises a one-cycle illegal-operation pulse and changes no other state. After halt, the unit ignores every strobe until a restart loads a new program counter.

Top module: `vdp_flow_unit`

## Requirements
- R1: After reset, pc_o, bank_o, x_o, y_o and depth_o are 0, and running_o and illegal_o are 0.
- R2: start_i sets running_o, loads pc_o from start_addr_i and clears depth_o to 0 in the next cycle. It takes precedence over any strobe in the same cycle.
- R3: op_bank_i loads bank_o from addr_i[3:0]. op_jump_i sets pc_o to {bank_o, addr_i[11:0]}.
- R4: op_call_i with depth_o below 8 saves pc_o on the stack, increments depth_o and sets pc_o to {bank_o, addr_i}.
- R5: op_ret_i with depth_o above 0 decrements depth_o and sets pc_o to the most recently saved address. Nested calls unwind in last-in, first-out order.
- R6: op_ret_i with depth_o equal to 0 drives illegal_o high for exactly one cycle and leaves pc_o and depth_o unchanged.
- R7: op_call_i with depth_o equal to 8 drives illegal_o high for one cycle and leaves pc_o and depth_o unchanged.
- R8: op_ldx_i copies addr_i into x_o. op_ldy_i copies addr_i into y_o.
- R9: op_xmsb_i adds 2048 to x_o modulo 4096. op_ymsb_i does the same to y_o.
- R10: op_halt_i clears running_o. While running_o is 0, every instruction strobe leaves pc_o, bank_o, x_o, y_o and depth_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart: set running and load the program counter |
| start_addr_i | input | 16 | Program counter value loaded on restart |
| addr_i | input | 12 | Address/data field of the current instruction |
| op_jump_i | input | 1 | Jump strobe |
| op_call_i | input | 1 | Call (jump to subroutine) strobe |
| op_ret_i | input | 1 | Return strobe |
| op_bank_i | input | 1 | Set-bank strobe |
| op_ldx_i | input | 1 | Load X strobe |
| op_ldy_i | input | 1 | Load Y strobe |
| op_xmsb_i | input | 1 | Add most significant step to X |
| op_ymsb_i | input | 1 | Add most significant step to Y |
| op_halt_i | input | 1 | Halt strobe |
| pc_o | output | 16 | Display program counter |
| bank_o | output | 4 | Bank register |
| x_o | output | 12 | X position |
| y_o | output | 12 | Y position |
| depth_o | output | 4 | Number of saved return addresses |
| running_o | output | 1 | Running flag |
| illegal_o | output | 1 | One-cycle illegal-operation pulse |

## Verification
The bench runs jumps under two different bank values, which shows whether the bank really forms the upper address bits. It nests calls eight deep and then unwinds them. Because every saved address is distinct, a wrong stack order or a wrong pointer adjustment gives a visibly wrong program counter. The fault cases cover a return on an empty stack and a call on a full stack, which tests both edges of the depth count against the error pulse and its one-cycle length. Position loads use values near the top of the range, so the 2048 step must wrap, and strobes sent while halted show whether the running flag really gates all state.

// File: rtl/vdp_flow_pkg.sv
package vdp_flow_pkg;
    localparam int unsigned OFS_W  = 12;
    localparam int unsigned BANK_W = 4;
    localparam int unsigned ADDR_W = OFS_W + BANK_W;

    typedef enum logic [3:0] {
        OP_NONE, OP_JUMP, OP_CALL, OP_RET, OP_BANK,
        OP_LDX, OP_LDY, OP_XMSB, OP_YMSB, OP_HALT
    } flow_op_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  x;
        logic [OFS_W-1:0]  y;
        logic              running;
        logic              illegal;
    } flow_state_t;
endpackage

// File: rtl/vdp_op_decode.sv
module vdp_op_decode
    import vdp_flow_pkg::*;
(
    input  logic     enable_i,
    input  logic     jump_i,
    input  logic     call_i,
    input  logic     ret_i,
    input  logic     bank_i,
    input  logic     ldx_i,
    input  logic     ldy_i,
    input  logic     xmsb_i,
    input  logic     ymsb_i,
    input  logic     halt_i,
    output flow_op_t op_o
);
    // Strobes are expected one-hot; a fixed priority keeps the result defined anyway.
    always_comb begin
        op_o = OP_NONE;
        if (enable_i) begin
            if      (halt_i) op_o = OP_HALT;
            else if (jump_i) op_o = OP_JUMP;
            else if (call_i) op_o = OP_CALL;
            else if (ret_i)  op_o = OP_RET;
            else if (bank_i) op_o = OP_BANK;
            else if (ldx_i)  op_o = OP_LDX;
            else if (ldy_i)  op_o = OP_LDY;
            else if (xmsb_i) op_o = OP_XMSB;
            else if (ymsb_i) op_o = OP_YMSB;
        end
    end
endmodule

// File: rtl/vdp_pos_step.sv
module vdp_pos_step
    import vdp_flow_pkg::*;
(
    input  flow_op_t         op_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [OFS_W-1:0] x_i,
    input  logic [OFS_W-1:0] y_i,
    output logic [OFS_W-1:0] x_o,
    output logic [OFS_W-1:0] y_o
);
    localparam logic [OFS_W-1:0] MSB_STEP = OFS_W'(1) << (OFS_W - 1);

    always_comb begin
        x_o = x_i;
        y_o = y_i;
        unique case (op_i)
            OP_LDX:  x_o = addr_i;
            OP_LDY:  y_o = addr_i;
            OP_XMSB: x_o = x_i + MSB_STEP;   // wraps modulo 2**OFS_W
            OP_YMSB: y_o = y_i + MSB_STEP;
            default: ;
        endcase
    end
endmodule

// File: rtl/vdp_ret_stack.sv
module vdp_ret_stack
    import vdp_flow_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_data_i,
    output logic [ADDR_W-1:0] top_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o,
    output logic              empty_o
);
    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic [IDX_W-1:0]  wr_idx, top_idx;

    assign wr_idx  = IDX_W'(cnt_q);
    assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
    assign top_o   = mem_q[top_idx];
    assign count_o = cnt_q;
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                  cnt_d = '0;
        else if (push_i && !full_o)   cnt_d = cnt_q + CNT_W'(1);
        else if (pop_i && !empty_o)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        if (!clear_i && push_i && !full_o) mem_q[wr_idx] <= push_data_i;
    end
endmodule

// File: rtl/vdp_flow_unit.sv
module vdp_flow_unit
    import vdp_flow_pkg::*;
#(
    parameter int unsigned STK_DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic              op_jump_i,
    input  logic              op_call_i,
    input  logic              op_ret_i,
    input  logic              op_bank_i,
    input  logic              op_ldx_i,
    input  logic              op_ldy_i,
    input  logic              op_xmsb_i,
    input  logic              op_ymsb_i,
    input  logic              op_halt_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [OFS_W-1:0]  x_o,
    output logic [OFS_W-1:0]  y_o,
    output logic [CNT_W-1:0]  depth_o,
    output logic              running_o,
    output logic              illegal_o
);
    flow_state_t       st_d, st_q;
    flow_op_t          op;
    logic [OFS_W-1:0]  x_nx, y_nx;
    logic [ADDR_W-1:0] target, stk_top;
    logic              stk_push, stk_pop, stk_clr, stk_full, stk_empty;

    vdp_op_decode u_dec (
        .enable_i (st_q.running && !start_i),
        .jump_i   (op_jump_i),
        .call_i   (op_call_i),
        .ret_i    (op_ret_i),
        .bank_i   (op_bank_i),
        .ldx_i    (op_ldx_i),
        .ldy_i    (op_ldy_i),
        .xmsb_i   (op_xmsb_i),
        .ymsb_i   (op_ymsb_i),
        .halt_i   (op_halt_i),
        .op_o     (op)
    );

    vdp_pos_step u_pos (
        .op_i   (op),
        .addr_i (addr_i),
        .x_i    (st_q.x),
        .y_i    (st_q.y),
        .x_o    (x_nx),
        .y_o    (y_nx)
    );

    vdp_ret_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (stk_clr),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_data_i (st_q.pc),
        .top_o       (stk_top),
        .count_o     (depth_o),
        .full_o      (stk_full),
        .empty_o     (stk_empty)
    );

    // Bank register sits directly above the offset field.
    assign target = {st_q.bank, addr_i};

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        st_d.x       = x_nx;
        st_d.y       = y_nx;
        stk_push     = 1'b0;
        stk_pop      = 1'b0;
        stk_clr      = 1'b0;
        if (start_i) begin
            st_d.running = 1'b1;
            st_d.pc      = start_addr_i;
            stk_clr      = 1'b1;
        end else begin
            unique case (op)
                OP_JUMP: st_d.pc = target;
                OP_CALL: begin
                    if (stk_full) begin
                        st_d.illegal = 1'b1;
                    end else begin
                        stk_push = 1'b1;
                        st_d.pc  = target;
                    end
                end
                OP_RET: begin
                    if (stk_empty) begin
                        st_d.illegal = 1'b1;
                    end else begin
                        stk_pop = 1'b1;
                        st_d.pc = stk_top;
                    end
                end
                OP_BANK: st_d.bank    = addr_i[BANK_W-1:0];
                OP_HALT: st_d.running = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o      = st_q.pc;
    assign bank_o    = st_q.bank;
    assign x_o       = st_q.x;
    assign y_o       = st_q.y;
    assign running_o = st_q.running;
    assign illegal_o = st_q.illegal;
endmodule

// File: rtl/vdp_flow_checker.sv
module vdp_flow_checker
    import vdp_flow_pkg::*;
#(
    parameter int unsigned STK_DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(STK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [OFS_W-1:0]  addr_i,
    input logic              op_jump_i,
    input logic              op_call_i,
    input logic              op_ret_i,
    input logic              op_bank_i,
    input logic              op_ldx_i,
    input logic              op_ldy_i,
    input logic              op_xmsb_i,
    input logic              op_ymsb_i,
    input logic              op_halt_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [OFS_W-1:0]  x_o,
    input logic [OFS_W-1:0]  y_o,
    input logic [CNT_W-1:0]  depth_o,
    input logic              running_o,
    input logic              illegal_o
);
    logic active;
    assign active = running_o && !start_i;

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> running_o && depth_o == '0);

    p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active && op_jump_i |=> pc_o == {$past(bank_o), $past(addr_i)});

    p_call_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active && op_call_i && depth_o < CNT_W'(STK_DEPTH) |=> depth_o == $past(depth_o) + CNT_W'(1));

    p_ret_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active && op_ret_i && depth_o != '0 |=> depth_o == $past(depth_o) - CNT_W'(1) && !illegal_o);

    p_ret_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && op_ret_i && depth_o == '0 |=> illegal_o && $stable(pc_o) && $stable(depth_o));

    p_call_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active && op_call_i && depth_o == CNT_W'(STK_DEPTH) |=> illegal_o && $stable(pc_o) && $stable(depth_o));

    p_ldx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active && op_ldx_i |=> x_o == $past(addr_i));

    p_xmsb_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active && op_xmsb_i |=> x_o == $past(x_o) + OFS_W'(2048));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o && !start_i |=> $stable(pc_o) && $stable(x_o) && $stable(y_o) && $stable(bank_o) && !running_o);

    p_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_jump_i, op_call_i, op_ret_i, op_bank_i, op_ldx_i,
                  op_ldy_i, op_xmsb_i, op_ymsb_i, op_halt_i}));

    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= CNT_W'(STK_DEPTH));
endmodule

bind vdp_flow_unit vdp_flow_checker #(.STK_DEPTH(STK_DEPTH)) u_chk (.*);

// File: tb/vdp_flow_unit_bench.sv
module vdp_flow_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] start_addr_i = '0;
    logic [11:0] addr_i = '0;
    logic [8:0]  strb = '0;   // {halt,ymsb,xmsb,ldy,ldx,bank,ret,call,jump}
    logic [15:0] pc_o;
    logic [3:0]  bank_o, depth_o;
    logic [11:0] x_o, y_o;
    logic        running_o, illegal_o;

    localparam logic [8:0] S_JUMP = 9'h001, S_CALL = 9'h002, S_RET = 9'h004,
                           S_BANK = 9'h008, S_LDX = 9'h010, S_LDY = 9'h020,
                           S_XMSB = 9'h040, S_YMSB = 9'h080, S_HALT = 9'h100;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    vdp_flow_unit u_vdp_flow_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .addr_i(addr_i),
        .op_jump_i(strb[0]), .op_call_i(strb[1]), .op_ret_i(strb[2]),
        .op_bank_i(strb[3]), .op_ldx_i(strb[4]), .op_ldy_i(strb[5]),
        .op_xmsb_i(strb[6]), .op_ymsb_i(strb[7]), .op_halt_i(strb[8]),
        .pc_o(pc_o), .bank_o(bank_o), .x_o(x_o), .y_o(y_o), .depth_o(depth_o),
        .running_o(running_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one strobe for one cycle; returns at the next negedge with results visible.
    task automatic op(input logic [8:0] s, input logic [11:0] a);
        @(negedge clk);
        strb   = s;
        addr_i = a;
        @(negedge clk);
        strb   = '0;
    endtask

    task automatic restart(input logic [15:0] a);
        @(negedge clk);
        start_i      = 1'b1;
        start_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "pc", pc_o, 0);
        chk("R1", "bank", bank_o, 0);
        chk("R1", "x", x_o, 0);
        chk("R1", "y", y_o, 0);
        chk("R1", "depth", depth_o, 0);
        chk("R1", "running", running_o, 0);
        chk("R1", "illegal", illegal_o, 0);
    endtask

    task automatic t_start;
        restart(16'h0100);
        chk("R2", "running", running_o, 1);
        chk("R2", "pc", pc_o, 16'h0100);
        chk("R2", "depth", depth_o, 0);
    endtask

    task automatic t_ret_empty;
        op(S_RET, 12'h0);
        chk("R6", "illegal", illegal_o, 1);
        chk("R6", "pc", pc_o, 16'h0100);
        chk("R6", "depth", depth_o, 0);
        op(9'h0, 12'h0);
        chk("R6", "illegal pulse length", illegal_o, 0);
    endtask

    task automatic t_jump;
        op(S_BANK, 12'h005);
        chk("R3", "bank", bank_o, 5);
        op(S_JUMP, 12'hABC);
        chk("R3", "pc bank 5", pc_o, 16'h5ABC);
        op(S_BANK, 12'hFF2);
        chk("R3", "bank low bits", bank_o, 2);
        op(S_JUMP, 12'h100);
        chk("R3", "pc bank 2", pc_o, 16'h2100);
    endtask

    task automatic t_call_nest;
        logic [15:0] saved [8];
        for (int i = 0; i < 8; i++) begin
            saved[i] = pc_o;
            op(S_CALL, 12'h200 + 12'(i));
            chk("R4", "pc after call", pc_o, 16'h2200 + i);
            chk("R4", "depth after call", depth_o, i + 1);
        end
        op(S_CALL, 12'h777);
        chk("R7", "illegal on full", illegal_o, 1);
        chk("R7", "pc held", pc_o, 16'h2207);
        chk("R7", "depth held", depth_o, 8);
        for (int i = 7; i >= 0; i--) begin
            op(S_RET, 12'h0);
            chk("R5", "pc after return", pc_o, saved[i]);
            chk("R5", "depth after return", depth_o, i);
            chk("R5", "no error", illegal_o, 0);
        end
    endtask

    task automatic t_pos;
        op(S_LDX, 12'd3000);
        chk("R8", "x load", x_o, 3000);
        op(S_LDY, 12'd100);
        chk("R8", "y load", y_o, 100);
        chk("R8", "x kept", x_o, 3000);
        op(S_XMSB, 12'h0);
        chk("R9", "x wrap", x_o, 952);
        op(S_XMSB, 12'h0);
        chk("R9", "x second step", x_o, 3000);
        op(S_YMSB, 12'h0);
        chk("R9", "y step", y_o, 2148);
        chk("R9", "x untouched", x_o, 3000);
    endtask

    task automatic t_halt;
        logic [15:0] pc_keep;
        pc_keep = pc_o;
        op(S_HALT, 12'h0);
        chk("R10", "running", running_o, 0);
        op(S_LDX, 12'h123);
        chk("R10", "x ignored", x_o, 3000);
        op(S_JUMP, 12'h456);
        chk("R10", "jump ignored", pc_o, pc_keep);
        op(S_BANK, 12'h009);
        chk("R10", "bank ignored", bank_o, 2);
        op(S_CALL, 12'h010);
        chk("R10", "call ignored", depth_o, 0);
        // restart wins over a same-cycle strobe
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 16'h3333; strb = S_LDX; addr_i = 12'h001;
        @(negedge clk);
        start_i = 1'b0; strb = '0;
        chk("R2", "restart pc", pc_o, 16'h3333);
        chk("R2", "restart over strobe", x_o, 3000);
        chk("R2", "running again", running_o, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_ret_empty();
        t_jump();
        t_call_nest();
        t_pos();
        t_halt();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule